// File: doc/BRIEF.md
# Multi-Lane Symbol Deskew Buffer

This block sits behind the symbol decoders of a link with up to four lanes. The lanes carry symbols that were sent together, but they arrive with different delays. Each lane writes its decoded bytes and K flags into a small circular store. The block then finds the comma K symbol that opens every training or skip ordered set. It records how many symbol times each active lane's comma trails the first one seen. From these times it sets a read delay per lane, so that the lane which arrived first waits longest and all commas leave the block together.

All lanes share one input valid strobe: a symbol is taken on every lane in each clock where the strobe is high. The tolerance is six symbol times. If any active lane has not shown its comma within that window, the block raises an error flag and keeps the delays it already has. Once an alignment succeeds, the delays stay frozen. A new measurement takes place only when an ordered set begins while the realign request is held. In single-lane mode, lane 0 passes with no added delay and the done flag is forced high.

The width code must be held stable while a measurement is in progress.

Top module: `deskew_align`

## Requirements
- R1: A measurement starts on a valid clock in which the block is armed and at least one active lane carries a comma marker, which is K flag high with byte 0xBC. The block is armed after reset until the first successful alignment, and later whenever `realign` is high.
- R2: On each valid clock, the output of an active lane takes the symbol that lane received d+1 valid clocks earlier. Here d = (latest comma arrival time among the active lanes) − (this lane's arrival time). Arrival times count valid symbols from the start of the measurement, with 0 for the starting clock.
- R3: When every active lane has shown its comma within six valid symbols of the start, the new delays are loaded, `deskew_done` is high from the following clock, and `deskew_err` clears.
- R4: If a measurement reaches its sixth valid symbol after the start and some active lane still has no comma, `deskew_err` goes high on the following clock. The delays and `deskew_done` stay unchanged.
- R5: While aligned and `realign` is low, further commas leave every delay unchanged.
- R6: With `realign` high, the next comma on an active lane begins a new measurement. Until that measurement succeeds, the old delays remain in use.
- R7: With `lane_width` = 2'b00 (one lane), lane 0 uses delay 0, and `deskew_done` is high from the clock after this width is applied.
- R8: Only lanes below the active count take part (1 for 2'b00, 2 for 2'b01, 4 for 2'b10 or 2'b11). Inactive lanes output zero data with K low, and their commas are ignored.
- R9: A clock with `in_vld` low changes neither the outputs, the stored symbols nor the measurement, even when commas are present on the inputs.
- R10: During reset and on the first clock after it, all outputs are zero and both flags are low, except that R7 raises `deskew_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | One symbol present on every lane this clock |
| in_data | input | LANES*DW | Decoded bytes, lane i at bits [i*DW +: DW] |
| in_k | input | LANES | K flag per lane |
| lane_width | input | 2 | Active lane count code: 00 one, 01 two, 1x four |
| realign | input | 1 | Request a new measurement at the next comma |
| out_data | output | LANES*DW | Aligned bytes, registered |
| out_k | output | LANES | Aligned K flags, registered |
| deskew_done | output | 1 | A valid alignment is in use, or single-lane mode |
| deskew_err | output | 1 | Latest measurement exceeded the skew window |

## Verification
Lane data is due on the clock edge that accepts a valid symbol, and it carries the symbol taken d+1 valid edges earlier. The new delays take effect from the valid edge after the one that completes the measurement. `deskew_done` follows one edge after completion or after the width change, and `deskew_err` follows one edge after the window expires. The bench's model advances at every rising edge with those same latencies and is compared at every falling edge. Lane data is compared only once the model holds enough history since reset, because the store itself is not cleared.

// File: rtl/deskew_pkg.sv
`timescale 1ns/1ps
package deskew_pkg;
  localparam logic [7:0] COMMA_BYTE = 8'hBC;

  typedef enum logic [1:0] {
    WID_X1 = 2'b00,
    WID_X2 = 2'b01,
    WID_X4 = 2'b10
  } wid_e;

  function automatic int unsigned lanes_of(input logic [1:0] code, input int unsigned cap);
    int unsigned n;
    case (code)
      2'b00:   n = 1;
      2'b01:   n = 2;
      default: n = 4;
    endcase
    return (n > cap) ? cap : n;
  endfunction
endpackage

// File: rtl/lane_delay_line.sv
`timescale 1ns/1ps
module lane_delay_line #(
  parameter int unsigned DW       = 8,
  parameter int unsigned MAX_SKEW = 6,
  parameter int unsigned DLY_W    = $clog2(MAX_SKEW + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             active,
  input  logic [DW-1:0]    din,
  input  logic             kin,
  input  logic [DLY_W-1:0] dly,
  output logic [DW-1:0]    dout,
  output logic             kout
);
  localparam int unsigned AW    = $clog2(MAX_SKEW + 2);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW:0]    store [DEPTH];
  logic [AW-1:0]  wr_ptr;
  logic [AW-1:0]  rd_addr;

  // no reset on the store so it maps onto RAM
  always_ff @(posedge clk) begin
    if (vld) store[wr_ptr] <= {kin, din};
  end

  always_ff @(posedge clk) begin
    if (rst)      wr_ptr <= '0;
    else if (vld) wr_ptr <= wr_ptr + AW'(1);
  end

  assign rd_addr = wr_ptr - AW'(dly) - AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      kout <= 1'b0;
    end else if (vld) begin
      if (active) {kout, dout} <= store[rd_addr];
      else        {kout, dout} <= '0;
    end
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !vld |=> $stable({kout, dout})); // R9
  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (vld && !active) |=> (dout == '0 && !kout)); // R8
endmodule

// File: rtl/skew_meter.sv
`timescale 1ns/1ps
module skew_meter #(
  parameter int unsigned LANES    = 4,
  parameter int unsigned MAX_SKEW = 6,
  parameter int unsigned DLY_W    = $clog2(MAX_SKEW + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   vld_i,
  input  logic [LANES-1:0]       marker_i,
  input  logic [LANES-1:0]       active_i,
  input  logic                   realign_i,
  output logic [LANES*DLY_W-1:0] dly_o,
  output logic                   aligned_o,
  output logic                   fin_o,
  output logic                   err_o
);
  localparam logic [DLY_W-1:0] LAST_STEP = DLY_W'(MAX_SKEW);

  logic             meas_q, aligned_q, err_q;
  logic [DLY_W-1:0] cnt_q;
  logic [LANES-1:0] seen_q, seen_n, hit;
  logic [DLY_W-1:0] t_q [LANES];
  logic [DLY_W-1:0] t_n [LANES];
  logic [DLY_W-1:0] dly_q [LANES];
  logic [DLY_W-1:0] maxt;
  logic             armed, start, step, all_seen, fin, fail;

  assign armed = !aligned_q || realign_i;

  always_comb begin
    hit    = marker_i & active_i;
    start  = 1'b0;
    seen_n = seen_q;
    for (int i = 0; i < LANES; i++) t_n[i] = t_q[i];
    if (!meas_q) begin
      start  = vld_i && armed && (|hit);
      seen_n = hit;
      for (int i = 0; i < LANES; i++) t_n[i] = '0;
    end else if (vld_i) begin
      for (int i = 0; i < LANES; i++) begin
        if (hit[i] && !seen_q[i]) begin
          seen_n[i] = 1'b1;
          t_n[i]    = cnt_q;
        end
      end
    end
    all_seen = ((seen_n & active_i) == active_i);
    step     = start || (meas_q && vld_i);
    fin      = step && all_seen;
    fail     = meas_q && vld_i && !all_seen && (cnt_q == LAST_STEP);
    maxt     = '0;
    for (int i = 0; i < LANES; i++) begin
      if (active_i[i] && t_n[i] > maxt) maxt = t_n[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      meas_q    <= 1'b0;
      aligned_q <= 1'b0;
      err_q     <= 1'b0;
      cnt_q     <= '0;
      seen_q    <= '0;
      for (int i = 0; i < LANES; i++) begin
        t_q[i]   <= '0;
        dly_q[i] <= '0;
      end
    end else if (fin) begin
      meas_q    <= 1'b0;
      aligned_q <= 1'b1;
      err_q     <= 1'b0;
      for (int i = 0; i < LANES; i++)
        dly_q[i] <= active_i[i] ? (maxt - t_n[i]) : '0;
    end else if (fail) begin
      meas_q <= 1'b0;
      err_q  <= 1'b1;
    end else if (step) begin
      meas_q <= 1'b1;
      cnt_q  <= start ? DLY_W'(1) : cnt_q + DLY_W'(1);
      seen_q <= seen_n;
      for (int i = 0; i < LANES; i++) t_q[i] <= t_n[i];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_pack
    assign dly_o[g*DLY_W +: DLY_W] = dly_q[g];
  end

  assign aligned_o = aligned_q;
  assign fin_o     = fin;
  assign err_o     = err_q;

  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (rst)
    meas_q |-> (cnt_q <= LAST_STEP)); // R4
  AST_ERR_KEEPS_DELAYS: assert property (@(posedge clk) disable iff (rst)
    (err_q && !$past(err_q)) |-> (dly_o == $past(dly_o))); // R4
  AST_ALIGN_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(aligned_q) |-> aligned_q); // R5
  AST_OFFSETS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ($past(aligned_q) && !$past(realign_i) && !$past(meas_q)) |-> $stable(dly_o)); // R5
endmodule

// File: rtl/deskew_align.sv
`timescale 1ns/1ps
module deskew_align #(
  parameter int unsigned LANES    = 4,
  parameter int unsigned DW       = 8,
  parameter int unsigned MAX_SKEW = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_vld,
  input  logic [LANES*DW-1:0] in_data,
  input  logic [LANES-1:0]    in_k,
  input  logic [1:0]          lane_width,
  input  logic                realign,
  output logic [LANES*DW-1:0] out_data,
  output logic [LANES-1:0]    out_k,
  output logic                deskew_done,
  output logic                deskew_err
);
  import deskew_pkg::*;

  localparam int unsigned DLY_W = $clog2(MAX_SKEW + 1);

  logic [LANES-1:0]       active, marker;
  logic [LANES*DLY_W-1:0] dly_flat;
  logic                   aligned, fin, is_x1;
  int unsigned            n_act;

  assign n_act = lanes_of(lane_width, LANES);
  assign is_x1 = (wid_e'(lane_width) == WID_X1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DLY_W-1:0] eff_dly;
    assign active[g] = (g < n_act);
    assign marker[g] = in_k[g] && (in_data[g*DW +: DW] == COMMA_BYTE);
    assign eff_dly   = is_x1 ? '0 : dly_flat[g*DLY_W +: DLY_W];

    lane_delay_line #(.DW(DW), .MAX_SKEW(MAX_SKEW), .DLY_W(DLY_W)) u_line (
      .clk    (clk),
      .rst    (rst),
      .vld    (in_vld),
      .active (active[g]),
      .din    (in_data[g*DW +: DW]),
      .kin    (in_k[g]),
      .dly    (eff_dly),
      .dout   (out_data[g*DW +: DW]),
      .kout   (out_k[g])
    );
  end

  skew_meter #(.LANES(LANES), .MAX_SKEW(MAX_SKEW), .DLY_W(DLY_W)) u_meter (
    .clk       (clk),
    .rst       (rst),
    .vld_i     (in_vld),
    .marker_i  (marker),
    .active_i  (active),
    .realign_i (realign),
    .dly_o     (dly_flat),
    .aligned_o (aligned),
    .fin_o     (fin),
    .err_o     (deskew_err)
  );

  always_ff @(posedge clk) begin
    if (rst) deskew_done <= 1'b0;
    else     deskew_done <= is_x1 || aligned || fin;
  end

  AST_X1_DONE: assert property (@(posedge clk) disable iff (rst)
    is_x1 |=> deskew_done); // R7
  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (rst)
    fin |=> (deskew_done && !deskew_err)); // R3
endmodule

// File: tb/tb_deskew_align.sv
`timescale 1ns/1ps
module tb_deskew_align;
  localparam int L = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_vld = 1'b0;
  logic [L*8-1:0] in_data = '0;
  logic [L-1:0]  in_k = '0;
  logic [1:0]    lane_width = 2'b10;
  logic          realign = 1'b0;
  logic [L*8-1:0] out_data;
  logic [L-1:0]  out_k;
  logic          deskew_done, deskew_err;

  deskew_align dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data), .in_k(in_k),
    .lane_width(lane_width), .realign(realign), .out_data(out_data),
    .out_k(out_k), .deskew_done(deskew_done), .deskew_err(deskew_err)
  );

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  int skew [L];
  int n_sym = 0;
  bit finished = 0;

  // reference model state
  int hist [L][8];
  int hcnt [L];
  int exp_sym [L];
  bit known [L];
  bit exp_done, exp_err;
  bit m_meas, m_aligned, m_err;
  int m_cnt, m_dly [L], m_t [L];
  bit m_seen [L];

  function automatic int sym_at(int g);
    if (g < 0) return 9'h04A;
    if (g % 32 == 5) return 9'h1BC;
    return (g * 7 + 3) & 8'hFF;
  endfunction

  function automatic int act_count(logic [1:0] w);
    return (w == 2'b00) ? 1 : (w == 2'b01) ? 2 : 4;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int l = 0; l < L; l++) begin
        hcnt[l] = 0; exp_sym[l] = 0; known[l] = 1; m_dly[l] = 0; m_t[l] = 0; m_seen[l] = 0;
      end
      m_meas = 0; m_aligned = 0; m_err = 0; m_cnt = 0;
      exp_done = 0; exp_err = 0;
    end else begin
      int nl;
      nl = act_count(lane_width);
      if (in_vld) begin
        bit hitany, all, armed, start, fin, fail;
        int maxt;
        bit hit [L];
        for (int l = 0; l < L; l++) begin
          int eff;
          eff = (nl == 1) ? 0 : m_dly[l];
          if (l >= nl) begin exp_sym[l] = 0; known[l] = 1; end
          else if (hcnt[l] > eff) begin exp_sym[l] = hist[l][eff]; known[l] = 1; end
          else known[l] = 0;
          for (int j = 7; j > 0; j--) hist[l][j] = hist[l][j-1];
          hist[l][0] = {23'd0, in_k[l], in_data[l*8 +: 8]};
          if (hcnt[l] < 8) hcnt[l]++;
        end
        hitany = 0;
        for (int l = 0; l < L; l++) begin
          hit[l] = (l < nl) && in_k[l] && (in_data[l*8 +: 8] == 8'hBC);
          hitany |= hit[l];
        end
        armed = !m_aligned || realign;
        start = 0; fin = 0; fail = 0;
        if (!m_meas && armed && hitany) begin
          start = 1;
          for (int l = 0; l < L; l++) begin m_seen[l] = hit[l]; m_t[l] = 0; end
          m_cnt = 1;
        end else if (m_meas) begin
          for (int l = 0; l < L; l++)
            if (hit[l] && !m_seen[l]) begin m_seen[l] = 1; m_t[l] = m_cnt; end
        end
        if (start || m_meas) begin
          all = 1;
          for (int l = 0; l < nl; l++) all &= m_seen[l];
          if (all) begin
            maxt = 0;
            for (int l = 0; l < nl; l++) if (m_t[l] > maxt) maxt = m_t[l];
            for (int l = 0; l < L; l++) m_dly[l] = (l < nl) ? maxt - m_t[l] : 0;
            m_aligned = 1; m_err = 0; m_meas = 0;
          end else if (m_meas && m_cnt == 6) begin
            m_err = 1; m_meas = 0;
          end else begin
            if (m_meas) m_cnt++;
            m_meas = 1;
          end
        end
      end
      exp_done = m_aligned || (nl == 1);
      exp_err  = m_err;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      for (int l = 0; l < L; l++)
        if (known[l]) check("R2 lane data", {out_k[l], out_data[l*8 +: 8]}, exp_sym[l]);
      check("R3 done flag", deskew_done, exp_done);
      check("R4 error flag", deskew_err, exp_err);
    end
  end

  task automatic run(input int cyc, input int gap_pct);
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      in_vld = (($urandom % 100) >= gap_pct);
      for (int l = 0; l < L; l++) begin
        int s;
        if (!in_vld) s = 9'h1BC;                     // R9: commas with strobe low
        else if (l >= act_count(lane_width) && ($urandom % 4 == 0)) s = 9'h1BC; // R8
        else s = sym_at(n_sym - skew[l]);
        in_k[l] = s[8];
        in_data[l*8 +: 8] = s[7:0];
      end
      if (in_vld) n_sym++;
    end
  endtask

  task automatic set_skew(input int a, input int b, input int c, input int d);
    skew[0] = a; skew[1] = b; skew[2] = c; skew[3] = d;
  endtask

  task automatic lanes_equal(input string tag);
    @(negedge clk);
    for (int l = 1; l < act_count(lane_width); l++)
      check(tag, out_data[l*8 +: 8], out_data[7:0]);
  endtask

  initial begin
    set_skew(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R10 reset data", out_data, 0);
    check("R10 reset done", deskew_done, 0);
    check("R10 reset err", deskew_err, 0);
    rst = 1'b0;
    // R1 R2 R3: first alignment in four-lane mode
    set_skew(0, 2, 5, 1);
    run(100, 0);
    check("R1 first alignment done", deskew_done, 1);
    lanes_equal("R2 lanes aligned");
    // R5: new skew, no request, delays stay
    set_skew(6, 0, 3, 0);
    run(80, 0);
    check("R5 no realign keeps done", deskew_done, 1);
    // R6 R3: realign, spread of exactly six
    realign = 1'b1;
    run(40, 0);
    realign = 1'b0;
    run(40, 0);
    lanes_equal("R6 realigned at six");
    // R4: spread of seven fails, old delays kept
    set_skew(0, 7, 0, 0);
    realign = 1'b1;
    run(40, 0);
    realign = 1'b0;
    run(40, 0);
    check("R4 error raised", deskew_err, 1);
    check("R4 done kept", deskew_done, 1);
    // R3: recovery clears error
    set_skew(1, 0, 2, 0);
    realign = 1'b1;
    run(40, 0);
    realign = 1'b0;
    check("R3 error cleared", deskew_err, 0);
    // R9: strobe gaps during realign and streaming
    set_skew(2, 0, 1, 3);
    realign = 1'b1;
    run(120, 30);
    realign = 1'b0;
    run(80, 30);
    // R8: two lanes active
    lane_width = 2'b01;
    set_skew(0, 3, 0, 0);
    realign = 1'b1;
    run(60, 0);
    realign = 1'b0;
    run(40, 10);
    check("R8 lane 2 quiet", out_data[23:16], 0);
    check("R8 lane 3 quiet", out_k[3], 0);
    lanes_equal("R8 two lanes aligned");
    // R7: one lane
    lane_width = 2'b00;
    run(40, 0);
    check("R7 single lane done", deskew_done, 1);
    lane_width = 2'b10;
    run(40, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !finished) begin
      finished = 1;
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule